// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is the control port and settings store of a mixed-signal front end. An external host selects it with an active-low chip select and toggles a serial clock. Each transfer is sixteen bits long: an instruction byte that holds a read/write flag and a 7-bit register address, then one data byte. The stored settings leave the block as parallel control signals: a clock multiplier value with a bypass flag, an auxiliary clock divider ratio and its lock-indicator select, eight section power-down bits, and a 12-bit control word with two flag bits.

The port runs in one of two pin modes. In 4-wire mode, read data leaves on a dedicated output and the data line is only an input. In 3-wire mode, the data line becomes bidirectional. For this mode the block exposes an output value and an output enable that the pad ring merges into one pin. The bit order is also selectable: most significant bit first or least significant bit first. Both the bit order and the pin mode are held in the initialization register. Each is captured at the start of a transfer.

All serial inputs are synchronized into the system clock domain. A self-clearing software reset returns every register except the initialization register to its default. The active-low hardware reset clears everything, the initialization register included.

Top module: `cfgspi_regbank`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register holds its default. The initialization register (0x00) reads `{3'b000, MULT_DEFAULT}`, which is 0x01 by default. Registers 0x01 to 0x04 read 0x00. All parallel outputs show these values.
- R2: A transfer starts when `cs_n` falls. `sdio_i` is sampled on the first 16 rising edges of `sclk`. The first byte is the instruction: bit 7 set means read and clear means write, and bits 6:0 are the address. The second byte is the data. A write changes a register only after its sixteenth bit. A transfer cut short by `cs_n` rising changes nothing. Rising edges beyond the sixteenth are ignored.
- R3: Bit 6 of register 0x00 selects the shift order for both bytes and for read data. 0 means bit 7 is first; 1 means bit 0 is first. The value is captured when `cs_n` falls, so a write to this bit takes effect only from the next transfer. `lsb_first` shows the stored bit.
- R4: On a read, bit n of the data byte, taken in the active order, is valid on the output before the (9+n)th rising edge of `sclk`. The output changes only after falling edges. In 4-wire mode (bit 7 of 0x00 clear) the data leaves on `sdo_o` and `sdio_oe` stays low.
- R5: In 3-wire mode (bit 7 of 0x00 set), `sdio_oe` is high only during the data phase of a read, from the eighth rising edge until `cs_n` rises. In that phase the data appears on `sdio_o` and `sdo_o` stays 0. The mode bit is captured when `cs_n` falls.
- R6: Writing 0x00 with bit 5 set returns registers 0x01 to 0x04 to 0x00 in the same cycle. Register 0x00 takes the other written bits, and bit 5 always reads back 0.
- R7: Register 0x01 holds `refclk_div` in bits 5:0 and `lock_det_sel` in bit 7; bit 6 reads 0. Register 0x02 drives `pwrdn[7:0]` bit for bit. Register 0x03 holds control-word bits 3:0 in its bits 7:4, the flag level in bit 1 and the flag enable in bit 0; bits 3:2 read 0. Register 0x04 holds control-word bits 11:4. Addresses 0x05 to 0x7F read 0x00, and writes to them are ignored.
- R8: `pll_mult` shows bits 4:0 of register 0x00. `pll_bypass` is high exactly when that field equals 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data line, input side |
| sdio_o | output | 1 | Serial data line, output value in 3-wire mode |
| sdio_oe | output | 1 | Output enable for the data line in 3-wire mode |
| sdo_o | output | 1 | Dedicated serial output in 4-wire mode |
| pll_mult | output | 5 | Clock multiplier value |
| pll_bypass | output | 1 | High when the multiplier value is 1 |
| lsb_first | output | 1 | Stored bit-order select |
| three_wire | output | 1 | Stored pin-mode select |
| refclk_div | output | 6 | Auxiliary clock divider ratio |
| lock_det_sel | output | 1 | Selects the lock indicator on the auxiliary clock pin |
| pwrdn | output | 8 | Section power-down bits |
| sd_word | output | 12 | Control word |
| sd_flag_en | output | 1 | Flag enable bit |
| flag1_lvl | output | 1 | Flag level bit |

## Verification
Two events can land in the same commit cycle: the software reset clearing registers 0x01 to 0x04, and the write to register 0x00 that sets the new bit order, pin mode and multiplier. The bench provokes this with single writes to 0x00 that carry bit 5 together with a changed bit order. It also repeats the case inside constrained-random traffic. Each outcome is judged at the ports. The other registers must read zero, register 0x00 must read the written value with bit 5 clear, and the transfer that follows must decode correctly only in the newly selected order.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
   localparam int BYTE_W     = 8;
   localparam int ADDR_W     = 7;
   localparam int FRAME_BITS = 2 * BYTE_W;

   localparam logic [ADDR_W-1:0] ADR_INIT  = 7'h00;
   localparam logic [ADDR_W-1:0] ADR_CLK   = 7'h01;
   localparam logic [ADDR_W-1:0] ADR_PWDN  = 7'h02;
   localparam logic [ADDR_W-1:0] ADR_CWLO  = 7'h03;
   localparam logic [ADDR_W-1:0] ADR_CWHI  = 7'h04;

   // bit positions inside the initialization register
   localparam int INIT_SRST = 5;
   localparam int INIT_LSB  = 6;
   localparam int INIT_3W   = 7;

   // writable-bit masks of the registers
   localparam logic [BYTE_W-1:0] MASK_INIT = 8'hDF;
   localparam logic [BYTE_W-1:0] MASK_CLK  = 8'hBF;
   localparam logic [BYTE_W-1:0] MASK_CWLO = 8'hF3;
endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
   parameter int               STAGES  = 2,
   parameter int               W       = 1,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgspi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[s] <= RST_VAL;
            end else if (s == 0) begin
               chain[s] <= d;
            end else begin
               chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgspi_port.sv
module cfgspi_port
   import cfgspi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sclk_s,
   input  logic              din_s,
   input  logic              cfg_lsb,
   input  logic              cfg_3w,
   input  logic [BYTE_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              sdo_o,
   output logic              sdio_o,
   output logic              sdio_oe
);
   localparam int CNT_W = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] C_FRAME  = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] C_INSTR  = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] C_ILAST  = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] C_FLAST  = CNT_W'(FRAME_BITS - 1);

   logic              sclk_d, cs_n_d;
   logic [CNT_W-1:0]  cnt;
   logic              lsb_q, tw_q, is_read, rd_phase;
   logic [BYTE_W-1:0] sr, sr_next, out_sr;
   logic [ADDR_W-1:0] addr_q;
   logic              rise, fall, cs_act, cs_start, dout;

   assign rise     = sclk_s & ~sclk_d;
   assign fall     = ~sclk_s & sclk_d;
   assign cs_act   = ~cs_n_s;
   assign cs_start = ~cs_n_s & cs_n_d;
   assign sr_next  = lsb_q ? {din_s, sr[BYTE_W-1:1]} : {sr[BYTE_W-2:0], din_s};
   assign rd_addr  = sr_next[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         cs_n_d   <= 1'b1;
         cnt      <= '0;
         lsb_q    <= 1'b0;
         tw_q     <= 1'b0;
         is_read  <= 1'b0;
         rd_phase <= 1'b0;
         sr       <= '0;
         out_sr   <= '0;
         addr_q   <= '0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         sclk_d <= sclk_s;
         cs_n_d <= cs_n_s;
         wr_en  <= 1'b0;
         if (!cs_act) begin
            cnt      <= '0;
            rd_phase <= 1'b0;
         end else if (cs_start) begin
            cnt      <= '0;
            rd_phase <= 1'b0;
            lsb_q    <= cfg_lsb;
            tw_q     <= cfg_3w;
         end else if (rise && cnt < C_FRAME) begin
            sr  <= sr_next;
            cnt <= cnt + 1'b1;
            if (cnt == C_ILAST) begin
               is_read <= sr_next[BYTE_W-1];
               addr_q  <= sr_next[ADDR_W-1:0];
               if (sr_next[BYTE_W-1]) begin
                  rd_phase <= 1'b1;
                  out_sr   <= rd_data;
               end
            end
            if (cnt == C_FLAST && !is_read) begin
               wr_en   <= 1'b1;
               wr_addr <= addr_q;
               wr_data <= sr_next;
            end
         end else if (fall && rd_phase && cnt > C_INSTR) begin
            out_sr <= lsb_q ? {1'b0, out_sr[BYTE_W-1:1]} : {out_sr[BYTE_W-2:0], 1'b0};
         end
      end
   end

   assign dout    = lsb_q ? out_sr[0] : out_sr[BYTE_W-1];
   assign sdio_oe = rd_phase & tw_q;
   assign sdio_o  = sdio_oe & dout;
   assign sdo_o   = rd_phase & ~tw_q & dout;

   // R5
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !sdio_oe);
   // R2
   commit_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(rise) && cnt == C_FRAME);
   // R3
   order_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !cs_start) |=> $stable(lsb_q) && $stable(tw_q));
   // R4
   read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_phase) |-> cnt == C_INSTR);
endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
   import cfgspi_pkg::*;
#(
   parameter int MULT_DEFAULT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic [4:0]        pll_mult,
   output logic              pll_bypass,
   output logic              lsb_first,
   output logic              three_wire,
   output logic [5:0]        refclk_div,
   output logic              lock_det_sel,
   output logic [7:0]        pwrdn,
   output logic [11:0]       sd_word,
   output logic              sd_flag_en,
   output logic              flag1_lvl
);
   localparam logic [BYTE_W-1:0] INIT_RST = {3'b000, 5'(MULT_DEFAULT)};

   logic [BYTE_W-1:0] r_init, r_clk, r_pwdn, r_cwlo, r_cwhi;
   logic              srst;

   assign srst = wr_en && wr_addr == ADR_INIT && wr_data[INIT_SRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_init <= INIT_RST;
         r_clk  <= '0;
         r_pwdn <= '0;
         r_cwlo <= '0;
         r_cwhi <= '0;
      end else if (srst) begin
         r_init <= wr_data & MASK_INIT;
         r_clk  <= '0;
         r_pwdn <= '0;
         r_cwlo <= '0;
         r_cwhi <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_INIT: r_init <= wr_data & MASK_INIT;
            ADR_CLK:  r_clk  <= wr_data & MASK_CLK;
            ADR_PWDN: r_pwdn <= wr_data;
            ADR_CWLO: r_cwlo <= wr_data & MASK_CWLO;
            ADR_CWHI: r_cwhi <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_addr)
         ADR_INIT: rd_data = r_init;
         ADR_CLK:  rd_data = r_clk;
         ADR_PWDN: rd_data = r_pwdn;
         ADR_CWLO: rd_data = r_cwlo;
         ADR_CWHI: rd_data = r_cwhi;
         default:  rd_data = '0;
      endcase
   end

   assign pll_mult     = r_init[4:0];
   assign pll_bypass   = (r_init[4:0] == 5'd1);
   assign lsb_first    = r_init[INIT_LSB];
   assign three_wire   = r_init[INIT_3W];
   assign refclk_div   = r_clk[5:0];
   assign lock_det_sel = r_clk[7];
   assign pwrdn        = r_pwdn;
   assign sd_word      = {r_cwhi, r_cwlo[7:4]};
   assign sd_flag_en   = r_cwlo[0];
   assign flag1_lvl    = r_cwlo[1];

   // R6
   srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_INIT && wr_data[INIT_SRST])
      |=> (pwrdn == 8'h00 && sd_word == 12'h000 && refclk_div == 6'd0 && !lock_det_sel));
   // R2
   write_only_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({r_init, r_clk, r_pwdn, r_cwlo, r_cwhi}));
   // R6
   srst_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !r_init[INIT_SRST]);
endmodule

// File: rtl/cfgspi_regbank.sv
module cfgspi_regbank
   import cfgspi_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int MULT_DEFAULT = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_n,
   input  logic        sclk,
   input  logic        sdio_i,
   output logic        sdio_o,
   output logic        sdio_oe,
   output logic        sdo_o,
   output logic [4:0]  pll_mult,
   output logic        pll_bypass,
   output logic        lsb_first,
   output logic        three_wire,
   output logic [5:0]  refclk_div,
   output logic        lock_det_sel,
   output logic [7:0]  pwrdn,
   output logic [11:0] sd_word,
   output logic        sd_flag_en,
   output logic        flag1_lvl
);
   generate
      if (MULT_DEFAULT < 1 || MULT_DEFAULT > 31) begin : g_bad_mult
         $error("cfgspi_regbank: MULT_DEFAULT must lie in 1..31");
      end
   endgenerate

   logic [2:0]        sync_q;
   logic [BYTE_W-1:0] rd_data;
   logic [ADDR_W-1:0] rd_addr, wr_addr;
   logic [BYTE_W-1:0] wr_data;
   logic              wr_en;

   cfgspi_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b001)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sdio_i, sclk, cs_n}),
      .q     (sync_q)
   );

   cfgspi_port i_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n_s  (sync_q[0]),
      .sclk_s  (sync_q[1]),
      .din_s   (sync_q[2]),
      .cfg_lsb (lsb_first),
      .cfg_3w  (three_wire),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sdo_o   (sdo_o),
      .sdio_o  (sdio_o),
      .sdio_oe (sdio_oe)
   );

   cfgspi_regs #(.MULT_DEFAULT(MULT_DEFAULT)) i_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .rd_addr      (rd_addr),
      .rd_data      (rd_data),
      .pll_mult     (pll_mult),
      .pll_bypass   (pll_bypass),
      .lsb_first    (lsb_first),
      .three_wire   (three_wire),
      .refclk_div   (refclk_div),
      .lock_det_sel (lock_det_sel),
      .pwrdn        (pwrdn),
      .sd_word      (sd_word),
      .sd_flag_en   (sd_flag_en),
      .flag1_lvl    (flag1_lvl)
   );

   // R4
   sdo_idle_in_3w_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdio_oe |-> !sdo_o);
endmodule

// File: tb/test_cfgspi_regbank.sv
module test_cfgspi_regbank;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
   logic sdio_o, sdio_oe, sdo_o, pll_bypass, lsb_first, three_wire, lock_det_sel;
   logic sd_flag_en, flag1_lvl;
   logic [4:0] pll_mult;
   logic [5:0] refclk_div;
   logic [7:0] pwrdn;
   logic [11:0] sd_word;

   int n_checks = 0, n_fail = 0;
   logic [7:0] m_reg [0:4];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgspi_regbank i_cfgspi_regbank (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
      .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .pll_mult(pll_mult),
      .pll_bypass(pll_bypass), .lsb_first(lsb_first), .three_wire(three_wire),
      .refclk_div(refclk_div), .lock_det_sel(lock_det_sel), .pwrdn(pwrdn),
      .sd_word(sd_word), .sd_flag_en(sd_flag_en), .flag1_lvl(flag1_lvl)
   );

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void m_reset();
      m_reg[0] = 8'h01;
      for (int i = 1; i < 5; i++) m_reg[i] = 8'h00;
   endfunction

   function automatic logic [7:0] m_read(input logic [6:0] a);
      return (a < 7'd5) ? m_reg[a[2:0]] : 8'h00;
   endfunction

   function automatic void m_write(input logic [6:0] a, input logic [7:0] d);
      case (a)
         7'h00: begin
            m_reg[0] = d & 8'hDF;
            if (d[5]) for (int i = 1; i < 5; i++) m_reg[i] = 8'h00;
         end
         7'h01: m_reg[1] = d & 8'hBF;
         7'h02: m_reg[2] = d;
         7'h03: m_reg[3] = d & 8'hF3;
         7'h04: m_reg[4] = d;
         default: ;
      endcase
   endfunction

   // one transfer; nbits < 16 aborts it, extra adds sclk edges after the frame
   task automatic xfer(input logic rw, input logic [6:0] addr, input logic [7:0] wd,
                       input int nbits, input int extra, output logic [7:0] rd,
                       output logic oe_ok, output logic instr_oe, output logic sdo_bad);
      logic lsb = m_reg[0][6];
      logic tw  = m_reg[0][7];
      logic [15:0] frame = {rw, addr, wd};
      rd = 8'h00; oe_ok = 1'b1; instr_oe = 1'b0; sdo_bad = 1'b0;
      cs_n = 1'b0;
      wclk(HALF);
      for (int i = 0; i < nbits + extra; i++) begin
         int b   = i % 8;
         int idx = lsb ? b : 7 - b;
         if (i < 8)            sdio_i = frame[8 + idx];
         else if (i < 16)      sdio_i = rw ? 1'b0 : frame[idx];
         else                  sdio_i = 1'b1;
         wclk(HALF);
         if (i < 8 && sdio_oe) instr_oe = 1'b1;
         if (rw && i >= 8 && i < 16) begin
            rd[idx] = tw ? sdio_o : sdo_o;
            if (tw && (!sdio_oe || sdo_o)) oe_ok = 1'b0;
            if (!tw && sdio_oe) oe_ok = 1'b0;
            if (tw && sdo_o) sdo_bad = 1'b1;
         end
         sclk = 1'b1;
         wclk(HALF);
         sclk = 1'b0;
      end
      wclk(HALF);
      cs_n = 1'b1;
      wclk(2 * HALF);
      if (!rw && nbits == 16) m_write(addr, wd);
   endtask

   task automatic wr(input logic [6:0] a, input logic [7:0] d);
      logic [7:0] r; logic x, y, z;
      xfer(1'b0, a, d, 16, 0, r, x, y, z);
   endtask

   task automatic rd_chk(input string req, input logic [6:0] a);
      logic [7:0] r; logic ok, io, sb;
      xfer(1'b1, a, 8'h00, 16, 0, r, ok, io, sb);
      chk(req, r, m_read(a));
      chk({req, " oe"}, {ok, io, sb}, 3'b100);
   endtask

   task automatic out_chk();
      chk("R8", {pll_mult, pll_bypass}, {m_reg[0][4:0], m_reg[0][4:0] == 5'd1});
      chk("R3", {lsb_first, three_wire}, {m_reg[0][6], m_reg[0][7]});
      chk("R7", {refclk_div, lock_det_sel, pwrdn, sd_word, sd_flag_en, flag1_lvl},
          {m_reg[1][5:0], m_reg[1][7], m_reg[2], m_reg[4], m_reg[3][7:4], m_reg[3][0], m_reg[3][1]});
      chk("R5 idle", sdio_oe, 1'b0);
   endtask

   task automatic hw_reset();
      rst_n = 1'b0;
      wclk(3);
      rst_n = 1'b1;
      m_reset();
      wclk(3);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [7:0] r; logic ok, io, sb;
      void'($urandom(32'h5EED));
      m_reset();
      wclk(2);
      // R1: defaults while and after reset
      chk("R1 in reset", {pll_mult, pwrdn, sd_word, sdio_oe, sdo_o}, {5'd1, 8'h00, 12'h000, 2'b00});
      hw_reset();
      out_chk();
      for (int a = 0; a < 5; a++) rd_chk("R1", 7'(a));
      // R7 / R2: register map, 4-wire MSB-first
      wr(7'h02, 8'hA5); out_chk(); rd_chk("R2", 7'h02);
      wr(7'h01, 8'hFF); out_chk(); rd_chk("R7 clk", 7'h01);
      wr(7'h03, 8'hFF); wr(7'h04, 8'hAB); out_chk();
      rd_chk("R7 cwlo", 7'h03); rd_chk("R7 cwhi", 7'h04);
      wr(7'h55, 8'hFF); out_chk(); rd_chk("R7 unmapped", 7'h55);
      // R2: aborted transfer, extra edges after the frame
      xfer(1'b0, 7'h02, 8'h0F, 12, 0, r, ok, io, sb);
      chk("R2 abort", pwrdn, 8'hA5);
      xfer(1'b0, 7'h02, 8'h3C, 16, 5, r, ok, io, sb);
      chk("R2 extra", pwrdn, 8'h3C);
      // R8: multiplier field and bypass
      wr(7'h00, 8'h05); out_chk(); chk("R8 m5", pll_bypass, 1'b0);
      wr(7'h00, 8'h01); out_chk(); chk("R8 m1", pll_bypass, 1'b1);
      // R3: order change applies from the next transfer
      wr(7'h00, 8'h41); out_chk();
      wr(7'h02, 8'h12); out_chk(); rd_chk("R3 lsb", 7'h02);
      // R5: switch to 3-wire, read through the bidirectional line
      wr(7'h00, 8'hC1); out_chk();
      xfer(1'b1, 7'h02, 8'h00, 16, 0, r, ok, io, sb);
      chk("R5 data", r, 8'h12);
      chk("R5 oe", {ok, io, sb}, 3'b100);
      chk("R5 released", sdio_oe, 1'b0);
      // R6: software reset together with a mode change
      wr(7'h01, 8'h2A); wr(7'h04, 8'h77);
      wr(7'h00, 8'h23); out_chk();
      chk("R6 cleared", {pwrdn, sd_word, refclk_div}, 26'h0);
      rd_chk("R6 init", 7'h00);
      wr(7'h02, 8'h81);
      wr(7'h00, 8'h62); out_chk();
      chk("R6 lsb kept", lsb_first, 1'b1);
      chk("R6 pd", pwrdn, 8'h00);
      wr(7'h04, 8'hC3); out_chk(); rd_chk("R6 next lsb", 7'h04);
      // R1: hardware reset also restores the initialization register
      wr(7'h00, 8'hDE);
      hw_reset(); out_chk();
      rd_chk("R1 after hw", 7'h00);
      // constrained random traffic
      for (int t = 0; t < 60; t++) begin
         logic [6:0] a = 7'($urandom_range(0, 6));
         logic [7:0] d = 8'($urandom);
         if ($urandom_range(0, 1) == 0) begin
            wr(a, d); out_chk();
         end else begin
            rd_chk("R4 rand", a);
         end
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule